// File: doc/BRIEF.md
# Programming Mode Unlock Sequencer

This block stands between the outside pins of a one-time-programmable memory device and its programming path. After power-on the part is in standard mode, and no write can reach the memory array. To switch into programming mode, an external programmer holds the internal core reset low. It then places a fixed sequence of key bytes on an 8-bit parallel port and clocks each byte in with pulses on a dedicated programming clock pin. That pin is asynchronous to the sampling clock of the block.

The pin and the port pass through two-flop synchronizers. A pulse counts as a step only if it is a rising edge followed by a falling edge and if the pin stayed high for at least `MIN_PULSE` sampling cycles. The port byte is captured at the rising edge of each pulse. The block ignores all pulses until a power-on settling counter of `POR_SETTLE` cycles has expired. A wrong byte returns the sequencer to its locked idle state. Once the block is in programming mode, it gates write requests to the memory so that only addresses inside the selected memory size get through.

States:
- `S_WAIT_POR`: settling after power-on.
- `S_IDLE`: armed and locked.
- `S_KEY1`: first byte accepted.
- `S_KEY2`: second byte accepted.
- `S_PROG`: programming mode.

Transitions:
- settle-done: from `S_WAIT_POR` to `S_IDLE`.
- key-match: from `S_IDLE` to `S_KEY1`, from `S_KEY1` to `S_KEY2`, and from `S_KEY2` to `S_PROG`.
- key-miss: from any key state to `S_IDLE`.
- hold-abort: from any state after settling to `S_IDLE` while `core_hold` is high.

Top module: `prog_unlock_seq`

## Requirements
- R1: While `por_n` is low, and for `POR_SETTLE` cycles after it rises, `seq_step` is 0, `pgm_mode` is 0 and `pgm_wr_en` is 0. After that, `seq_step` becomes 1.
- R2: While `core_hold` is high, every state after settling goes to step 1 with `pgm_mode` at 0, and pulses do not advance the sequence.
- R3: From step 1, with `core_hold` low, three valid pulses are needed to enter programming mode. They must capture the port bytes A5h, 5Ah and A5h, in that order. Step encoding: 0 wait, 1 idle, 2 first key, 3 second key, 4 programming. The steps go 1, 2, 3, 4, and at step 4 `pgm_mode` is 1.
- R4: A valid pulse that captures a byte other than the one expected at steps 1 to 3 returns `seq_step` to 1. A new attempt must start again with A5h.
- R5: A pulse whose synchronized high time is shorter than `MIN_PULSE` sampling cycles leaves `seq_step` unchanged, whatever byte is on the port.
- R6: `pgm_wr_en` is 1 only when `pgm_mode` is 1 and `pgm_wr_req` is 1.
- R7: `pgm_wr_en` also requires `pgm_addr` to be at most the last address for `mem_sel`. The encodings are 0 = 0.5 KB (01FFh), 1 = 1 KB (03FFh), 2 = 2 KB (07FFh) and 3 = 4 KB (0FFFh).
- R8: Once in programming mode, further pulses with any byte leave the block in step 4. It leaves only through `por_n` or `core_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_hold | input | 1 | Internal core reset level; key entry accepted only while low |
| pgm_clk_pin | input | 1 | External programming clock pin, asynchronous |
| port_pins | input | 8 | Parallel port carrying key bytes, asynchronous |
| mem_sel | input | 2 | Memory size select (0.5/1/2/4 KB) |
| pgm_addr | input | ADDR_W | Address of a programming write |
| pgm_wr_req | input | 1 | Programming write request |
| pgm_mode | output | 1 | 1 in programming mode, 0 in standard mode |
| pgm_wr_en | output | 1 | Write enable gated by mode and address range |
| seq_step | output | 3 | Current sequence step (encoding in R3) |

## Verification
The assertions assume that `mem_sel`, `pgm_addr` and `pgm_wr_req` are synchronous to `clk`, and that `core_hold` changes only on clock edges. They make no assumption about the pin and port timing, because those signals are synchronized. The stimulus changes every input at the falling clock edge. It holds the port byte steady for several cycles before each rising pin edge and through it, so the synchronized byte and the synchronized edge always line up. Pulse widths sit well clear of `MIN_PULSE`, one side or the other, so that no case depends on synchronizer phase.

// File: rtl/pus_pkg.sv
package pus_pkg;
    typedef enum logic [2:0] {
        S_WAIT_POR = 3'd0,
        S_IDLE     = 3'd1,
        S_KEY1     = 3'd2,
        S_KEY2     = 3'd3,
        S_PROG     = 3'd4
    } pus_state_e;

    localparam logic [7:0] KEY_A = 8'hA5;
    localparam logic [7:0] KEY_B = 8'h5A;
endpackage

// File: rtl/pus_sync.sv
module pus_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[i] <= '0;
            end else begin
                if (i == 0) chain[i] <= d;
                else        chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pus_por_timer.sv
module pus_por_timer #(
    parameter int SETTLE = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign armed = (cnt == LIMIT);
endmodule

// File: rtl/pus_pulse_det.sv
module pus_pulse_det #(
    parameter int MIN_W = 250,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_s,
    input  logic [DW-1:0] data_s,
    output logic          step_ok,
    output logic [DW-1:0] step_data
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_W);

    logic          pin_d;
    logic          in_pulse;
    logic [CW-1:0] hi_cnt;
    logic          rise, fall;

    assign rise = pin_s & ~pin_d;
    assign fall = ~pin_s & pin_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d     <= 1'b0;
            in_pulse  <= 1'b0;
            hi_cnt    <= '0;
            step_ok   <= 1'b0;
            step_data <= '0;
        end else begin
            pin_d   <= pin_s;
            step_ok <= 1'b0;
            if (rise) begin
                in_pulse  <= 1'b1;
                hi_cnt    <= CW'(1);
                step_data <= data_s;
            end else if (pin_s && in_pulse) begin
                if (hi_cnt != LIMIT) hi_cnt <= hi_cnt + 1'b1;
            end else if (fall) begin
                in_pulse <= 1'b0;
                step_ok  <= in_pulse && (hi_cnt >= LIMIT);
            end
        end
    end
endmodule

// File: rtl/pus_addr_chk.sv
module pus_addr_chk #(
    parameter int ADDR_W = 12,
    parameter int BASE_W = 9
) (
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    logic [ADDR_W:0] last;

    always_comb begin
        last     = ((ADDR_W+1)'(1) << (BASE_W + int'(sel))) - 1'b1;
        in_range = ({1'b0, addr} <= last);
    end
endmodule

// File: rtl/prog_unlock_seq.sv
module prog_unlock_seq
    import pus_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 250,
    parameter int POR_SETTLE  = 12_500_000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              core_hold,
    input  logic              pgm_clk_pin,
    input  logic [7:0]        port_pins,
    input  logic [1:0]        mem_sel,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic              pgm_wr_req,
    output logic              pgm_mode,
    output logic              pgm_wr_en,
    output logic [2:0]        seq_step
);
    localparam int SW = 9;

    logic [SW-1:0] raw_bus, sync_bus;
    logic          armed;
    logic          step_ok;
    logic [7:0]    step_data;
    logic          addr_ok;

    pus_state_e state, state_nx;

    assign raw_bus = {pgm_clk_pin, port_pins};

    pus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(por_n), .d(raw_bus), .q(sync_bus)
    );

    pus_por_timer #(.SETTLE(POR_SETTLE)) u_por (
        .clk(clk), .rst_n(por_n), .armed(armed)
    );

    pus_pulse_det #(.MIN_W(MIN_PULSE), .DW(8)) u_pulse (
        .clk(clk), .rst_n(por_n),
        .pin_s(sync_bus[SW-1]), .data_s(sync_bus[7:0]),
        .step_ok(step_ok), .step_data(step_data)
    );

    pus_addr_chk #(.ADDR_W(ADDR_W), .BASE_W(9)) u_addr (
        .sel(mem_sel), .addr(pgm_addr), .in_range(addr_ok)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= S_WAIT_POR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_WAIT_POR: if (armed) state_nx = S_IDLE;
            S_IDLE: begin
                if (!core_hold && step_ok)
                    state_nx = (step_data == KEY_A) ? S_KEY1 : S_IDLE;
            end
            S_KEY1: begin
                if (core_hold)    state_nx = S_IDLE;
                else if (step_ok) state_nx = (step_data == KEY_B) ? S_KEY2 : S_IDLE;
            end
            S_KEY2: begin
                if (core_hold)    state_nx = S_IDLE;
                else if (step_ok) state_nx = (step_data == KEY_A) ? S_PROG : S_IDLE;
            end
            S_PROG: if (core_hold) state_nx = S_IDLE;
            default: state_nx = S_WAIT_POR;
        endcase
    end

    always_comb begin
        pgm_mode  = (state == S_PROG);
        pgm_wr_en = pgm_mode && pgm_wr_req && addr_ok;
        seq_step  = state;
    end
endmodule

// File: rtl/pus_checker.sv
module pus_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              por_n,
    input logic              core_hold,
    input logic [1:0]        mem_sel,
    input logic [ADDR_W-1:0] pgm_addr,
    input logic              pgm_wr_req,
    input logic              pgm_mode,
    input logic              pgm_wr_en,
    input logic [2:0]        seq_step
);
    logic [ADDR_W:0] top_addr;
    assign top_addr = ((ADDR_W+1)'(512) << mem_sel) - 1'b1;

    p_wren_mode_r6: assert property (@(posedge clk) disable iff (!por_n)
        pgm_wr_en |-> (pgm_mode && pgm_wr_req));

    p_wren_range_r7: assert property (@(posedge clk) disable iff (!por_n)
        pgm_wr_en |-> ({1'b0, pgm_addr} <= top_addr));

    p_hold_clears_r2: assert property (@(posedge clk) disable iff (!por_n)
        (core_hold && seq_step != 3'd0) |=> (!pgm_mode && seq_step == 3'd1));

    p_mode_latched_r8: assert property (@(posedge clk) disable iff (!por_n)
        (pgm_mode && !core_hold) |=> pgm_mode);

    p_entry_path_r3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pgm_mode) |-> ($past(seq_step) == 3'd3));

    p_step_legal_r3: assert property (@(posedge clk) disable iff (!por_n)
        seq_step <= 3'd4);

    p_wait_locked_r1: assert property (@(posedge clk) disable iff (!por_n)
        (seq_step == 3'd0) |-> (!pgm_mode && !pgm_wr_en));
endmodule

bind prog_unlock_seq pus_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .por_n(por_n), .core_hold(core_hold), .mem_sel(mem_sel),
    .pgm_addr(pgm_addr), .pgm_wr_req(pgm_wr_req), .pgm_mode(pgm_mode),
    .pgm_wr_en(pgm_wr_en), .seq_step(seq_step)
);

// File: tb/prog_unlock_seq_tb.sv
module prog_unlock_seq_tb;
    localparam int ADDR_W = 12;
    localparam int SETTLE = 40;
    localparam int MINW   = 4;
    localparam int LONG_W = 7;
    localparam int SHRT_W = 2;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              core_hold = 1'b0;
    logic              pgm_clk_pin = 1'b0;
    logic [7:0]        port_pins = 8'h00;
    logic [1:0]        mem_sel = 2'd0;
    logic [ADDR_W-1:0] pgm_addr = '0;
    logic              pgm_wr_req = 1'b0;
    logic              pgm_mode, pgm_wr_en;
    logic [2:0]        seq_step;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    prog_unlock_seq #(.ADDR_W(ADDR_W), .MIN_PULSE(MINW), .POR_SETTLE(SETTLE)) u_dut (
        .clk(clk), .por_n(por_n), .core_hold(core_hold), .pgm_clk_pin(pgm_clk_pin),
        .port_pins(port_pins), .mem_sel(mem_sel), .pgm_addr(pgm_addr),
        .pgm_wr_req(pgm_wr_req), .pgm_mode(pgm_mode), .pgm_wr_en(pgm_wr_en),
        .seq_step(seq_step)
    );

    // byte, long pulse, expected step afterwards
    typedef struct packed {
        logic [7:0] b;
        logic       lng;
        logic [2:0] exp_step;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 1'b1, 3'd2},  // R3 first key
        '{8'h5A, 1'b1, 3'd3},  // R3 second key
        '{8'h00, 1'b1, 3'd1},  // R4 wrong third byte
        '{8'hA5, 1'b0, 3'd1},  // R5 short pulse ignored
        '{8'hA5, 1'b1, 3'd2},  // R3 restart
        '{8'hA5, 1'b1, 3'd1},  // R4 wrong second byte
        '{8'hA5, 1'b1, 3'd2},  // R3 restart
        '{8'h5A, 1'b0, 3'd2},  // R5 short pulse ignored
        '{8'h5A, 1'b1, 3'd3},  // R3 second key
        '{8'hA5, 1'b1, 3'd4},  // R3 enters programming mode
        '{8'h00, 1'b1, 3'd4},  // R8 latched
        '{8'h5A, 1'b1, 3'd4}   // R8 latched
    };

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] b, input int w);
        @(negedge clk);
        port_pins = b;
        cyc(4);
        pgm_clk_pin = 1'b1;
        cyc(w);
        pgm_clk_pin = 1'b0;
        cyc(8);
        #1;
    endtask

    task automatic wr_case(input logic [1:0] s, input int a, input int expv, input string req);
        @(negedge clk);
        mem_sel = s; pgm_addr = ADDR_W'(a); pgm_wr_req = 1'b1;
        #1;
        chk(req, int'(pgm_wr_en), expv);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        cyc(3);
        #1;
        chk("R1 step in reset", int'(seq_step), 0);
        chk("R1 mode in reset", int'(pgm_mode), 0);
        @(negedge clk); por_n = 1'b1;
        pgm_wr_req = 1'b1;
        cyc(SETTLE - 5);
        #1;
        chk("R1 still settling", int'(seq_step), 0);
        chk("R1 no write while settling", int'(pgm_wr_en), 0);
        cyc(10);
        #1;
        chk("R1 armed idle", int'(seq_step), 1);
        chk("R6 locked blocks write", int'(pgm_wr_en), 0);
        pgm_wr_req = 1'b0;

        // R2: hold high, correct key ignored
        core_hold = 1'b1;
        pulse(8'hA5, LONG_W);
        chk("R2 hold blocks key", int'(seq_step), 1);
        core_hold = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pulse(VECS[i].b, VECS[i].lng ? LONG_W : SHRT_W);
            chk($sformatf("R3 R4 R5 R8 vector %0d step", i), int'(seq_step), int'(VECS[i].exp_step));
        end
        chk("R3 mode flag", int'(pgm_mode), 1);

        // R6 / R7 write gating
        @(negedge clk); pgm_wr_req = 1'b0; mem_sel = 2'd3; pgm_addr = '0; #1;
        chk("R6 no request", int'(pgm_wr_en), 0);
        wr_case(2'd0, 12'h1FF, 1, "R7 0.5KB last");
        wr_case(2'd0, 12'h200, 0, "R7 0.5KB over");
        wr_case(2'd1, 12'h3FF, 1, "R7 1KB last");
        wr_case(2'd1, 12'h400, 0, "R7 1KB over");
        wr_case(2'd2, 12'h7FF, 1, "R7 2KB last");
        wr_case(2'd2, 12'h800, 0, "R7 2KB over");
        wr_case(2'd3, 12'hFFF, 1, "R7 4KB last");
        wr_case(2'd3, 12'h000, 1, "R6 write in mode");
        @(negedge clk); pgm_wr_req = 1'b0;

        // R2: hold aborts programming mode
        core_hold = 1'b1;
        cyc(2); #1;
        chk("R2 hold clears mode", int'(pgm_mode), 0);
        chk("R2 hold step", int'(seq_step), 1);
        @(negedge clk); core_hold = 1'b0;
        pulse(8'hA5, LONG_W);
        chk("R2 after release", int'(seq_step), 2);
        core_hold = 1'b1;
        cyc(2); #1;
        chk("R2 hold aborts partial", int'(seq_step), 1);
        @(negedge clk); core_hold = 1'b0;

        // R4: new attempt must start with first key
        pulse(8'h5A, LONG_W);
        chk("R4 restart needs first key", int'(seq_step), 1);

        // R1: power-on reset clears programming mode
        pulse(8'hA5, LONG_W);
        pulse(8'h5A, LONG_W);
        pulse(8'hA5, LONG_W);
        chk("R8 re-entry", int'(seq_step), 4);
        @(negedge clk); por_n = 1'b0; #1;
        chk("R1 por clears mode", int'(pgm_mode), 0);
        chk("R1 por step", int'(seq_step), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule